// File: doc/BRIEF.md
# Flash-to-RAM Address Overlay Remapper

This block sits between a 16-bit CPU address bus and the on-chip flash and RAM. It lets a small window of RAM take the place of part of the low flash area. Calibration tables and other parameters that normally live in flash can then be changed in real time, with no erase or program cycle. While an overlay is active, the RAM behind the window can be reached through two addresses: its own RAM address and the flash address it covers. Reads and writes work through both.

An 8-bit control register holds two overlay-select bits. It also holds clock-double, wait-mode and wait-count fields, which this block only stores and reads back. Each bus access is decoded in the same cycle. The block raises the flash or the RAM chip-select and drives the memory address. For an access that lands in the active window, that address is translated to the RAM address. The register is set to its initial value by reset and by hardware standby.

Top module: `ovl_remap`

## Requirements
- R1: While `rst_n` is low the control register is set to 0x08, and after reset it reads back 0x08 with no overlay active.
- R2: A cycle with `hw_stby` high sets the control register back to 0x08. This takes priority over a register write in the same cycle.
- R3: Bit 4 of the control register always reads 0. Writing 1 to it has no effect.
- R4: Bits 7..5 and 3..0 store the written value and read it back unchanged. Bit 5 is clock-double, bits 3..2 are wait mode and bits 1..0 are wait count. The register changes only on a write or on standby.
- R5: The overlay mode is register bits [7:6]. With mode 00, every flash address goes to flash with its address unchanged.
- R6: With mode 01, flash addresses 0x0080..0x00FF go to RAM at 0xF880..0xF8FF.
- R7: With mode 10, flash addresses 0x0080..0x017F go to RAM at 0xF880..0xF97F.
- R8: With mode 11, flash addresses 0x0000..0x007F go to RAM at 0xF800..0xF87F.
- R9: Addresses in the RAM range (0xF780..0xFF7F) always select RAM with the address unchanged, in every mode. This covers the overlaid locations at their own address.
- R10: Flash addresses (0x0000..0xDFFF) outside the active window select flash, with the address unchanged.
- R11: A write to a window address raises `ram_cs` and `ram_we` with the translated address. `flash_cs` stays low.
- R12: A new overlay mode applies to the first bus access in the cycle after the register write's clock edge.
- R13: `flash_cs` and `ram_cs` are never high together. Neither one is high with no request or for an address outside both memories.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_stby | input | 1 | Hardware standby entry, sets the register to its initial value |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | Bus access is a write |
| bus_addr | input | 16 | CPU address |
| flash_cs | output | 1 | Flash chip-select |
| ram_cs | output | 1 | RAM chip-select |
| ram_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | Memory address, translated for window hits |
| ovl_hit | output | 1 | Access was redirected by the overlay |

## Verification
The assertions check these rules on every cycle:
- the two chip-selects never overlap;
- a window hit always lands inside the 384-byte overlay RAM and always selects RAM;
- reserved bit 4 stays clear;
- the register holds its value unless a write or standby arrives;
- standby restores 0x08.

The exact window edges in each mode can only be shown by the bench's directed scenarios, because the assertions do not know which addresses should hit. The bench probes the first and last address of each window and its neighbours. It also checks that a mode change applies on the very next access and that writes through the window enable the RAM.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

   localparam int OVL_AW   = 16;
   localparam int OVL_DW   = 8;
   localparam int OVL_NMODE = 4;
   localparam logic [OVL_AW-1:0] OVL_RAM_SPAN = 16'h0180;

   typedef enum logic [1:0] {
      OVL_OFF   = 2'b00,
      OVL_SMALL = 2'b01,
      OVL_WIDE  = 2'b10,
      OVL_LOW   = 2'b11
   } ovl_mode_e;

   typedef struct packed {
      logic [OVL_AW-1:0] fbase;
      logic [OVL_AW-1:0] rbase;
      logic [OVL_AW-1:0] span;
   } ovl_win_t;

   // Window geometry per mode, relative to the overlay RAM base.
   function automatic ovl_win_t ovl_window(input logic [1:0] mode,
                                           input logic [OVL_AW-1:0] ram_base);
      ovl_win_t w;
      w = '0;
      case (mode)
         OVL_SMALL: begin w.fbase = 16'h0080; w.rbase = ram_base + 16'h0080; w.span = 16'h0080; end
         OVL_WIDE:  begin w.fbase = 16'h0080; w.rbase = ram_base + 16'h0080; w.span = 16'h0100; end
         OVL_LOW:   begin w.fbase = 16'h0000; w.rbase = ram_base;            w.span = 16'h0080; end
         default:   begin w.fbase = 16'h0000; w.rbase = ram_base;            w.span = 16'h0000; end
      endcase
      return w;
   endfunction

endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
   import ovl_pkg::*;
#(
   parameter logic [OVL_DW-1:0] RESET_VAL = 8'h08,
   parameter logic [OVL_DW-1:0] RSVD_MASK = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              wr,
   input  logic [OVL_DW-1:0] wdata,
   output logic [OVL_DW-1:0] q,
   output logic [1:0]        mode
);

   localparam logic [OVL_DW-1:0] KEEP_MASK = ~RSVD_MASK;

   initial begin
      assert ((RESET_VAL & RSVD_MASK) == '0)
         else $error("reset value sets a reserved bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RESET_VAL;
      else if (hw_stby) q <= RESET_VAL;
      else if (wr)      q <= wdata & KEEP_MASK;
   end

   assign mode = q[7:6];

   // R3: reserved bit never set
   a_r3_rsvd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (q & RSVD_MASK) == '0);

   // R2: standby restores initial value
   a_r2_stby_reset: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> q == RESET_VAL);

   // R4: contents held without write or standby
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !hw_stby) |=> $stable(q));

endmodule

// File: rtl/ovl_win_match.sv
module ovl_win_match
   import ovl_pkg::*;
#(
   parameter logic [OVL_AW-1:0] OVL_RAM_BASE = 16'hF800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [OVL_AW-1:0] addr,
   output logic              hit,
   output logic [OVL_AW-1:0] xaddr
);

   logic [OVL_NMODE-1:0] hit_v;
   logic [OVL_AW-1:0]    xl_v [OVL_NMODE];

   for (genvar m = 0; m < OVL_NMODE; m++) begin : g_mode
      localparam ovl_win_t W = ovl_window(m[1:0], OVL_RAM_BASE);
      logic [OVL_AW-1:0] off;
      assign off = addr - W.fbase;
      if (W.span == '0) begin : g_none
         assign hit_v[m] = 1'b0;
      end else begin : g_cmp
         assign hit_v[m] = (addr >= W.fbase) && (off < W.span);
      end
      assign xl_v[m] = off + W.rbase;
   end

   assign hit   = (mode != OVL_OFF) && hit_v[mode];
   assign xaddr = xl_v[mode];

   // R6/R7/R8: a window hit always lands inside the overlay RAM
   a_r8_xlat_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (xaddr >= OVL_RAM_BASE) &&
              ({1'b0, xaddr} < {1'b0, OVL_RAM_BASE} + {1'b0, OVL_RAM_SPAN}));

   // R5: no hit with overlay off
   a_r5_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OVL_OFF) |-> !hit);

endmodule

// File: rtl/ovl_steer.sv
module ovl_steer
   import ovl_pkg::*;
#(
   parameter logic [OVL_AW-1:0] FLASH_HI = 16'hDFFF,
   parameter logic [OVL_AW-1:0] RAM_LO   = 16'hF780,
   parameter logic [OVL_AW-1:0] RAM_HI   = 16'hFF7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [OVL_AW-1:0] addr,
   input  logic              hit,
   input  logic [OVL_AW-1:0] xaddr,
   output logic              flash_cs,
   output logic              ram_cs,
   output logic              ram_we,
   output logic [OVL_AW-1:0] mem_addr
);

   logic in_flash, in_ram;

   assign in_flash = (addr <= FLASH_HI);
   assign in_ram   = (addr >= RAM_LO) && (addr <= RAM_HI);

   assign flash_cs = req && in_flash && !hit;
   assign ram_cs   = req && (hit || in_ram);
   assign ram_we   = ram_cs && wr;
   assign mem_addr = hit ? xaddr : addr;

   // R13: chip-selects exclusive
   a_r13_cs_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(flash_cs && ram_cs));

   // R11: window hit always goes to RAM
   a_r11_hit_to_ram: assert property (@(posedge clk) disable iff (!rst_n)
      (req && hit) |-> (ram_cs && !flash_cs));

   // R13: no select without request
   a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> (!flash_cs && !ram_cs && !ram_we));

endmodule

// File: rtl/ovl_remap.sv
module ovl_remap
   import ovl_pkg::*;
#(
   parameter int                ADDR_W       = 16,
   parameter logic [15:0]       FLASH_HI     = 16'hDFFF,
   parameter logic [15:0]       RAM_LO       = 16'hF780,
   parameter logic [15:0]       RAM_HI       = 16'hFF7F,
   parameter logic [15:0]       OVL_RAM_BASE = 16'hF800,
   parameter logic [7:0]        REG_INIT     = 8'h08
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hw_stby,
   input  logic        reg_wr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic        bus_req,
   input  logic        bus_wr,
   input  logic [15:0] bus_addr,
   output logic        flash_cs,
   output logic        ram_cs,
   output logic        ram_we,
   output logic [15:0] mem_addr,
   output logic        ovl_hit
);

   localparam logic [16:0] OVL_END = {1'b0, OVL_RAM_BASE} + {1'b0, OVL_RAM_SPAN};

   initial begin
      assert (ADDR_W == OVL_AW) else $error("address width must match package");
      assert (FLASH_HI < RAM_LO) else $error("flash and RAM ranges overlap");
      assert (FLASH_HI >= 16'h017F) else $error("flash too small for overlay windows");
      assert (OVL_RAM_BASE >= RAM_LO && OVL_END <= {1'b0, RAM_HI} + 17'd1)
         else $error("overlay RAM outside RAM range");
   end

   logic [1:0]  mode;
   logic        hit;
   logic [15:0] xaddr;

   ovl_ctrl_reg #(.RESET_VAL(REG_INIT), .RSVD_MASK(8'h10)) u_reg (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
      .wr(reg_wr), .wdata(reg_wdata), .q(reg_rdata), .mode(mode)
   );

   ovl_win_match #(.OVL_RAM_BASE(OVL_RAM_BASE)) u_match (
      .clk(clk), .rst_n(rst_n), .mode(mode), .addr(bus_addr),
      .hit(hit), .xaddr(xaddr)
   );

   ovl_steer #(.FLASH_HI(FLASH_HI), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)) u_steer (
      .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(bus_wr), .addr(bus_addr),
      .hit(hit), .xaddr(xaddr), .flash_cs(flash_cs), .ram_cs(ram_cs),
      .ram_we(ram_we), .mem_addr(mem_addr)
   );

   assign ovl_hit = bus_req && hit;

endmodule

// File: tb/ovl_remap_test.sv
`timescale 1ns/1ps
module ovl_remap_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_stby = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        flash_cs, ram_cs, ram_we, ovl_hit;
   logic [15:0] mem_addr;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ovl_remap uut (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .flash_cs(flash_cs),
      .ram_cs(ram_cs), .ram_we(ram_we), .mem_addr(mem_addr), .ovl_hit(ovl_hit)
   );

   task automatic chk_reg(input logic [7:0] exp, input string tag);
      checks++;
      if (reg_rdata !== exp) begin
         errors++;
         $display("FAIL %s reg_rdata actual %h expected %h", tag, reg_rdata, exp);
      end
   endtask

   // Write register at a falling edge, let one rising edge capture it.
   task automatic write_reg(input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // kind: 0 none, 1 flash, 2 ram
   task automatic probe(input logic [15:0] a, input logic w, input int kind,
                        input logic [15:0] exp_addr, input logic exp_hit,
                        input string tag);
      logic ef, er;
      ef = (kind == 1);
      er = (kind == 2);
      bus_req = 1'b1; bus_wr = w; bus_addr = a;
      #1;
      checks++;
      if (flash_cs !== ef || ram_cs !== er || ram_we !== (er && w) ||
          ovl_hit !== exp_hit || (kind != 0 && mem_addr !== exp_addr)) begin
         errors++;
         $display("FAIL %s addr %h actual f=%b r=%b we=%b hit=%b a=%h expected f=%b r=%b we=%b hit=%b a=%h",
                  tag, a, flash_cs, ram_cs, ram_we, ovl_hit, mem_addr,
                  ef, er, er && w, exp_hit, exp_addr);
      end
      bus_req = 1'b0; bus_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk_reg(8'h08, "R1");
      probe(16'h0080, 1'b0, 1, 16'h0080, 1'b0, "R1");
      probe(16'h0000, 1'b0, 1, 16'h0000, 1'b0, "R5");
   endtask

   task automatic t_register();
      write_reg(8'hFF);
      chk_reg(8'hEF, "R3");
      write_reg(8'h2B);
      chk_reg(8'h2B, "R4");
      write_reg(8'h14);
      chk_reg(8'h04, "R3");
      repeat (3) @(negedge clk);
      chk_reg(8'h04, "R4");
      @(negedge clk);
      hw_stby = 1'b1; reg_wr = 1'b1; reg_wdata = 8'hC3;
      @(negedge clk);
      hw_stby = 1'b0; reg_wr = 1'b0;
      chk_reg(8'h08, "R2");
   endtask

   task automatic t_mode_off();
      write_reg(8'h0F);
      probe(16'h0080, 1'b1, 1, 16'h0080, 1'b0, "R5");
      probe(16'h017F, 1'b0, 1, 16'h017F, 1'b0, "R5");
      probe(16'hF880, 1'b0, 2, 16'hF880, 1'b0, "R9");
   endtask

   task automatic t_mode_small();
      write_reg(8'h48);
      // first access right after the write edge uses the new mode
      probe(16'h0080, 1'b0, 2, 16'hF880, 1'b1, "R12");
      chk_reg(8'h48, "R4");
      probe(16'h007F, 1'b0, 1, 16'h007F, 1'b0, "R10");
      probe(16'h00FF, 1'b0, 2, 16'hF8FF, 1'b1, "R6");
      probe(16'h0100, 1'b0, 1, 16'h0100, 1'b0, "R10");
      probe(16'h00C3, 1'b1, 2, 16'hF8C3, 1'b1, "R11");
      probe(16'hF8C3, 1'b1, 2, 16'hF8C3, 1'b0, "R9");
   endtask

   task automatic t_mode_wide();
      write_reg(8'h80);
      probe(16'h0080, 1'b0, 2, 16'hF880, 1'b1, "R7");
      probe(16'h017F, 1'b0, 2, 16'hF97F, 1'b1, "R7");
      probe(16'h0180, 1'b0, 1, 16'h0180, 1'b0, "R10");
      probe(16'h0000, 1'b0, 1, 16'h0000, 1'b0, "R10");
      probe(16'h0120, 1'b1, 2, 16'hF920, 1'b1, "R11");
      probe(16'hF97F, 1'b0, 2, 16'hF97F, 1'b0, "R9");
   endtask

   task automatic t_mode_low();
      write_reg(8'hC0);
      probe(16'h0000, 1'b0, 2, 16'hF800, 1'b1, "R8");
      probe(16'h007F, 1'b1, 2, 16'hF87F, 1'b1, "R8");
      probe(16'h0080, 1'b0, 1, 16'h0080, 1'b0, "R10");
      probe(16'hDFFF, 1'b0, 1, 16'hDFFF, 1'b0, "R10");
      probe(16'hF800, 1'b0, 2, 16'hF800, 1'b0, "R9");
   endtask

   task automatic t_outside();
      probe(16'hE800, 1'b0, 0, 16'h0000, 1'b0, "R13");
      probe(16'hFF80, 1'b1, 0, 16'h0000, 1'b0, "R13");
      bus_addr = 16'h0010;
      #1;
      checks++;
      if (flash_cs !== 1'b0 || ram_cs !== 1'b0) begin
         errors++;
         $display("FAIL R13 idle select actual f=%b r=%b expected f=0 r=0", flash_cs, ram_cs);
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_register();
      t_mode_off();
      t_mode_small();
      t_mode_wide();
      t_mode_low();
      t_outside();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule